// File: doc/BRIEF.md
# Serial DAC Command Front End

This block is the digital control side of a 12-bit voltage-output converter. A host sends 16-bit command words over a three-wire serial link made of an active-low select, a serial clock and a data line. The block samples the serial lines with its own system clock. It collects each word while select is low and acts on the word once select returns high. Its state is an input (staging) code, the code presented to the converter, a power-down flag, a general-purpose logic output driven by serial command, and the default level that output takes on a clear.

An asynchronous active-low clear input forces the converter code to zero or to half scale, as a strap input chooses. The same clear returns the logic output to its programmed default. A serial echo output repeats each received bit sixteen serial clocks later, so that several converters can share one select and one data path in a chain.

The receiver is a four-state machine: `RX_IDLE` (select high), `RX_SHIFT` (select low, bits counted), `RX_FIRE` (one cycle, word executed) and `RX_DROP` (one cycle, word discarded). It has these transitions. *Select fall* moves RX_IDLE to RX_SHIFT. *Frame complete* moves RX_SHIFT to RX_FIRE when select rises after exactly sixteen clocks. *Frame bad* moves RX_SHIFT to RX_DROP when select rises after any other count. *Return* moves both RX_FIRE and RX_DROP back to RX_IDLE.

Top module: `dac_serial_ctrl`

## Requirements
- R1: A word is 16 bits, shifted most significant first on rising serial clock edges while select is low. Bits 15..13 are the command, bits 12..1 are the 12-bit data, and bit 0 is ignored.
- R2: A word runs only when select rises after exactly 16 rising serial clock edges. Any other count leaves every register unchanged.
- R3: Command 001 writes the data to the input code only, and the converter code does not change. Command 011 copies the input code to the converter code.
- R4: Command 010 writes the data to both the input code and the converter code.
- R5: Commands 100 and 101 drive the logic output low and high. Command 111 stores data bit 0 (word bit 1) as the logic output's default and does not change the logic output itself.
- R6: Command 110 sets the power-down flag, and the logic output keeps its level. Commands 001, 010 and 011 clear the flag.
- R7: Command 000 changes nothing.
- R8: While clear is low with the strap low, the converter code is 0x000.
- R9: While clear is low with the strap high, the converter code is 0x800.
- R10: While clear is low, the logic output equals its programmed default. Clear leaves the power-down flag, the input code and the default unchanged.
- R11: After each falling serial clock edge while select is low, the echo output shows the data bit taken 16 rising edges earlier. It holds while select is high.
- R12: After reset the input code, logic output, default, power-down flag and echo output are 0. The converter code equals the clear value that the strap selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| clr_n | input | 1 | Asynchronous active-low clear |
| mid_sel | input | 1 | Strap: 0 clears to zero, 1 clears to half scale |
| dout | output | 1 | Serial echo for chaining |
| dac_code | output | 12 | Code presented to the converter |
| upo | output | 1 | Serial-controlled logic output |
| power_down | output | 1 | Power-down flag |

## Verification
Directed words tell the single-register commands apart from the two-register ones. Loading the input code alone and then updating shows that the staging path is separate from the direct load. Words cut at 15 or lengthened to 17 clocks show that counts near the valid one are rejected. A word with the ignored last bit set shows that it never reaches the data. Clears with each strap value, applied while the logic output differs from its default, separate the zero and half-scale paths and prove that the staging code survives a clear. A long run of seeded random words, lengths and clears then checks every echo bit against a model shift register.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int DATA_W  = 12;
    localparam int CMD_W   = 3;
    localparam int SUB_W   = 1;
    localparam int FRAME_W = CMD_W + DATA_W + SUB_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP       = 3'b000,
        CMD_LOAD_IN   = 3'b001,
        CMD_LOAD_BOTH = 3'b010,
        CMD_UPDATE    = 3'b011,
        CMD_UPO_LO    = 3'b100,
        CMD_UPO_HI    = 3'b101,
        CMD_SLEEP     = 3'b110,
        CMD_UPO_DFLT  = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_FIRE  = 2'd2,
        RX_DROP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= RST_VAL;
                else        pipe <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= {STAGES{RST_VAL}};
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacfe_rx.sv
module dacfe_rx
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              din_s,
    output cmd_e              cmd,
    output logic [DATA_W-1:0] data,
    output logic              fire,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              msb,
    output logic              bit_rise,
    output logic              bit_fall
);
    rx_state_e          state, nxt;
    logic               sclk_d;
    logic [FRAME_W-1:0] sr;
    logic               sclk_up, sclk_dn;

    assign sclk_up = sclk_s & ~sclk_d;
    assign sclk_dn = ~sclk_s & sclk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt      = state;
        fire     = 1'b0;
        bit_rise = 1'b0;
        bit_fall = 1'b0;
        unique case (state)
            RX_IDLE: begin
                if (!cs_n_s) nxt = RX_SHIFT;
            end
            RX_SHIFT: begin
                if (cs_n_s) begin
                    nxt = (bit_cnt == CNT_W'(FRAME_W)) ? RX_FIRE : RX_DROP;
                end else begin
                    bit_rise = sclk_up;
                    bit_fall = sclk_dn;
                end
            end
            RX_FIRE: begin
                fire = 1'b1;
                nxt  = RX_IDLE;
            end
            RX_DROP: begin
                nxt = RX_IDLE;
            end
        endcase
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            sr      <= '0;
            bit_cnt <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (state == RX_IDLE) begin
                bit_cnt <= '0;
            end else if (bit_rise) begin
                sr <= {sr[FRAME_W-2:0], din_s};
                if (bit_cnt != CNT_W'(FRAME_W + 1)) bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign cmd  = cmd_e'(sr[FRAME_W-1 -: CMD_W]);
    assign data = sr[SUB_W +: DATA_W];
    assign msb  = sr[FRAME_W-1];
endmodule

// File: rtl/dacfe_echo.sv
module dacfe_echo (
    input  logic clk,
    input  logic rst_n,
    input  logic msb,
    input  logic bit_rise,
    input  logic bit_fall,
    output logic dout
);
    logic pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            dout <= 1'b0;
        end else begin
            if (bit_rise) pend <= msb;
            if (bit_fall) dout <= pend;
        end
    end
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              mid_sel,
    input  logic              fire,
    input  cmd_e              cmd,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] dac_code,
    output logic              upo,
    output logic              upo_dflt,
    output logic              power_down
);
    logic [DATA_W-1:0] in_code;
    logic              clr_rst_n;
    logic ld_in, ld_dac, from_in, upo_wr, upo_val, go_sleep, wake, dflt_wr;

    assign clr_rst_n = rst_n & clr_n;

    always_comb begin
        ld_in    = 1'b0;
        ld_dac   = 1'b0;
        from_in  = 1'b0;
        upo_wr   = 1'b0;
        upo_val  = 1'b0;
        go_sleep = 1'b0;
        wake     = 1'b0;
        dflt_wr  = 1'b0;
        unique case (cmd)
            CMD_NOP: begin
            end
            CMD_LOAD_IN: begin
                ld_in = 1'b1;
                wake  = 1'b1;
            end
            CMD_LOAD_BOTH: begin
                ld_in  = 1'b1;
                ld_dac = 1'b1;
                wake   = 1'b1;
            end
            CMD_UPDATE: begin
                ld_dac  = 1'b1;
                from_in = 1'b1;
                wake    = 1'b1;
            end
            CMD_UPO_LO: begin
                upo_wr = 1'b1;
            end
            CMD_UPO_HI: begin
                upo_wr  = 1'b1;
                upo_val = 1'b1;
            end
            CMD_SLEEP: begin
                go_sleep = 1'b1;
            end
            CMD_UPO_DFLT: begin
                dflt_wr = 1'b1;
            end
        endcase
    end

    // registers the clear input forces
    always_ff @(posedge clk or negedge clr_rst_n) begin
        if (!clr_rst_n) begin
            dac_code <= mid_sel ? MID_CODE : '0;
            upo      <= upo_dflt & rst_n;
        end else if (fire) begin
            if (ld_dac) dac_code <= from_in ? in_code : data;
            if (upo_wr) upo <= upo_val;
        end
    end

    // registers the clear input leaves alone
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_code    <= '0;
            upo_dflt   <= 1'b0;
            power_down <= 1'b0;
        end else if (fire) begin
            if (ld_in)    in_code    <= data;
            if (dflt_wr)  upo_dflt   <= data[0];
            if (go_sleep) power_down <= 1'b1;
            else if (wake) power_down <= 1'b0;
        end
    end
endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              clr_n,
    input  logic              mid_sel,
    output logic              dout,
    output logic [DATA_W-1:0] dac_code,
    output logic              upo,
    output logic              power_down
);
    localparam int         N_LINES  = 3;
    localparam logic [2:0] LINE_RST = 3'b010;

    logic [N_LINES-1:0] raw_lines, sync_lines;
    cmd_e               rx_cmd;
    logic [DATA_W-1:0]  rx_data;
    logic               cmd_fire, rx_msb, rx_rise, rx_fall, upo_dflt;
    logic [CNT_W-1:0]   rx_cnt;

    assign raw_lines = {din, cs_n, sclk};

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_sync
            dacfe_sync #(
                .STAGES (SYNC_STAGES),
                .RST_VAL(LINE_RST[g])
            ) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (raw_lines[g]),
                .q    (sync_lines[g])
            );
        end
    endgenerate

    dacfe_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sync_lines[0]),
        .cs_n_s  (sync_lines[1]),
        .din_s   (sync_lines[2]),
        .cmd     (rx_cmd),
        .data    (rx_data),
        .fire    (cmd_fire),
        .bit_cnt (rx_cnt),
        .msb     (rx_msb),
        .bit_rise(rx_rise),
        .bit_fall(rx_fall)
    );

    dacfe_echo u_echo (
        .clk     (clk),
        .rst_n   (rst_n),
        .msb     (rx_msb),
        .bit_rise(rx_rise),
        .bit_fall(rx_fall),
        .dout    (dout)
    );

    dacfe_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .mid_sel   (mid_sel),
        .fire      (cmd_fire),
        .cmd       (rx_cmd),
        .data      (rx_data),
        .dac_code  (dac_code),
        .upo       (upo),
        .upo_dflt  (upo_dflt),
        .power_down(power_down)
    );
endmodule

// File: rtl/dac_serial_ctrl_chk.sv
module dac_serial_ctrl_chk
    import dacfe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              mid_sel,
    input logic              fire,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [DATA_W-1:0] dac_code,
    input logic              upo,
    input logic              upo_dflt,
    input logic              power_down
);
    // R2: a word only runs after a full count
    p_fire_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> bit_cnt == CNT_W'(FRAME_W));

    // R3: converter code moves only after an executed word
    p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(fire) && clr_n && $past(clr_n)) |-> $stable(dac_code));

    // R6: logic output holds while asleep
    p_sleep_upo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (power_down && $past(power_down) && !$past(fire) && clr_n && $past(clr_n))
        |-> $stable(upo));

    // R8: clear to zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && $past(!clr_n) && !mid_sel && $stable(mid_sel)) |-> dac_code == '0);

    // R9: clear to half scale
    p_clear_mid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && $past(!clr_n) && mid_sel && $stable(mid_sel)) |-> dac_code == MID_CODE);

    // R10: clear returns the logic output to its default
    p_clear_upo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n && $past(!clr_n) && $stable(upo_dflt)) |-> upo == upo_dflt);
endmodule

bind dac_serial_ctrl dac_serial_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .mid_sel   (mid_sel),
    .fire      (cmd_fire),
    .bit_cnt   (rx_cnt),
    .dac_code  (dac_code),
    .upo       (upo),
    .upo_dflt  (upo_dflt),
    .power_down(power_down)
);

// File: tb/dac_serial_ctrl_bench.sv
module dac_serial_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic clk = 1'b0;
    logic rst_n, cs_n, sclk, din, clr_n, mid_sel;
    logic dout, upo, power_down;
    logic [11:0] dac_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [11:0] m_in, m_dac;
    logic        m_pd, m_upo, m_dflt, m_pend, m_dout;
    logic [15:0] m_sr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_serial_ctrl u_dac_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .clr_n(clr_n), .mid_sel(mid_sel), .dout(dout), .dac_code(dac_code),
        .upo(upo), .power_down(power_down)
    );

    function automatic logic [11:0] clear_value(input logic strap);
        return strap ? 12'h800 : 12'h000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_exec(input logic [2:0] cmd, input logic [11:0] data);
        case (cmd)
            3'b001: begin m_in = data; m_pd = 1'b0; end
            3'b010: begin m_in = data; m_dac = data; m_pd = 1'b0; end
            3'b011: begin m_dac = m_in; m_pd = 1'b0; end
            3'b100: m_upo = 1'b0;
            3'b101: m_upo = 1'b1;
            3'b110: m_pd = 1'b1;
            3'b111: m_dflt = data[0];
            default: ;
        endcase
    endtask

    // one serial clock; checks the echo left by the previous falling edge (R11)
    task automatic sclk_cycle(input logic b);
        sclk = 1'b0;
        din  = b;
        wait_clk(HALF);
        check("R11 echo", 32'(dout), 32'(m_dout));
        sclk   = 1'b1;
        m_pend = m_sr[15];
        m_sr   = {m_sr[14:0], b};
        wait_clk(HALF);
        sclk   = 1'b0;
        m_dout = m_pend;
    endtask

    task automatic send_frame(input logic [2:0] cmd, input logic [11:0] data,
                              input logic sub, input int nbits, input string req);
        logic [15:0] w;
        w = {cmd, data, sub};
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sclk_cycle(i < 16 ? w[15-i] : 1'($urandom));
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
        if (nbits == 16) model_exec(cmd, data);
        check({req, " dac_code"}, 32'(dac_code), 32'(m_dac));
        check({req, " power_down"}, 32'(power_down), 32'(m_pd));
        check({req, " upo"}, 32'(upo), 32'(m_upo));
    endtask

    task automatic do_clear(input logic strap);
        mid_sel = strap;
        wait_clk(2);
        clr_n = 1'b0;
        wait_clk(3);
        check(strap ? "R9 clear mid" : "R8 clear zero", 32'(dac_code), 32'(clear_value(strap)));
        check("R10 clear upo", 32'(upo), 32'(m_dflt));
        check("R10 clear keeps pd", 32'(power_down), 32'(m_pd));
        clr_n = 1'b1;
        m_dac = clear_value(strap);
        m_upo = m_dflt;
        wait_clk(3);
        check("R10 after clear", 32'(dac_code), 32'(m_dac));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5c_0a17));
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; clr_n = 1'b1; mid_sel = 1'b0;
        m_in = '0; m_dac = '0; m_pd = 0; m_upo = 0; m_dflt = 0; m_pend = 0; m_dout = 0; m_sr = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R12 reset state
        check("R12 reset dac_code", 32'(dac_code), 32'h000);
        check("R12 reset upo", 32'(upo), 32'h0);
        check("R12 reset power_down", 32'(power_down), 32'h0);
        check("R12 reset dout", 32'(dout), 32'h0);

        send_frame(3'b001, 12'hABC, 1'b0, 16, "R3 load input only");
        send_frame(3'b011, 12'h000, 1'b0, 16, "R3 update from input");
        send_frame(3'b010, 12'h123, 1'b0, 16, "R4 load both");
        send_frame(3'b010, 12'hFFF, 1'b0, 15, "R2 short word");
        send_frame(3'b010, 12'hFFF, 1'b0, 17, "R2 long word");
        send_frame(3'b010, 12'h7FE, 1'b1, 16, "R1 trailing bit ignored");
        send_frame(3'b101, 12'h000, 1'b0, 16, "R5 upo high");
        send_frame(3'b111, 12'h001, 1'b0, 16, "R5 default write");
        send_frame(3'b100, 12'h000, 1'b0, 16, "R5 upo low");
        send_frame(3'b001, 12'h5A5, 1'b0, 16, "R10 stage before clear");
        do_clear(1'b1);
        send_frame(3'b011, 12'h000, 1'b0, 16, "R10 input kept over clear");
        send_frame(3'b101, 12'h000, 1'b0, 16, "R6 upo before sleep");
        send_frame(3'b110, 12'h000, 1'b0, 16, "R6 sleep keeps upo");
        send_frame(3'b000, 12'hFFF, 1'b1, 16, "R7 no operation");
        send_frame(3'b001, 12'h321, 1'b0, 16, "R6 load wakes");
        send_frame(3'b111, 12'h000, 1'b0, 16, "R5 default low");
        do_clear(1'b0);

        for (int k = 0; k < 260; k++) begin
            int n;
            n = 16;
            if (($urandom % 8) == 0) n = (($urandom % 2) == 0) ? 15 : 17;
            send_frame(3'($urandom), 12'($urandom), 1'($urandom), n, "R1 random word");
            if (($urandom % 10) == 0) do_clear(1'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule